// File: doc/BRIEF.md
# Soft Mute Ramp Controller

This block sits between a stereo sample source and the modulators of an audio output path. It multiplies each left and right sample by a shared gain so that the audio level never steps abruptly. A clock-ratio detector drives a validity flag. While that flag is low, the gain falls toward zero at one step per sample strobe. Once the gain reaches zero, both outputs sit at code zero, which is the quiescent midpoint for two's complement audio. When the flag returns high, a slow soft start brings the gain back to unity. The soft start is counted in sample strobes, so its duration tracks the sample rate.

The gain is a 16-bit unsigned fraction in which 32768 means unity. It changes only on a sample strobe. The ramp is symmetric in form and asymmetric in speed: a fast fall of 512 per strobe (64 strobes from unity) and a slow rise of 34 per strobe (964 strobes from zero, close to 20 ms at 48 kHz). If the flag changes in the middle of a ramp, the ramp turns around from the gain it has reached.

Top module: `soft_mute_ramp`

## Requirements
- R1: After a synchronous reset, the gain is zero, `muted_o` is 1, both outputs are code 0, and `out_stb_o` is 0.
- R2: `out_stb_o` is high for exactly the one clock that follows each cycle with `smp_stb_i` high. `left_o`, `right_o` and `muted_o` change only in that clock and hold their values at all other times.
- R3: On each strobe, each output equals (x*g + 16384) >>> 15, saturated to the signed 24-bit range. Here x is the input sample and g is the gain after that strobe's update.
- R4: A strobe with `clk_ok_i` = 1 raises the gain by 34, capped at 32768. From zero, unity is reached on the 964th such strobe. At unity, each output equals its input, including the extreme codes -8388608 and 8388607.
- R5: A strobe with `clk_ok_i` = 0 lowers the gain by 512, floored at 0. From unity, the gain reaches zero on the 64th such strobe.
- R6: A change of `clk_ok_i` during a ramp reverses the ramp from the current gain. No single strobe moves the gain by more than one step.
- R7: `muted_o` is 1 exactly when the gain after the last strobe is 0. While `muted_o` is 1, both outputs are code 0.
- R8: Changes of `clk_ok_i` with no strobe have no effect on the gain or the outputs.
- R9: While the gain is zero and `clk_ok_i` is 0, strobes keep the gain at zero and the outputs at code 0. The soft start begins only on a strobe that sees `clk_ok_i` = 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| smp_stb_i | input | 1 | One-cycle pulse per stereo sample |
| clk_ok_i | input | 1 | Clock ratio valid flag from the detector |
| left_i | input | 24 | Left sample, two's complement |
| right_i | input | 24 | Right sample, two's complement |
| left_o | output | 24 | Gain-scaled left sample |
| right_o | output | 24 | Gain-scaled right sample |
| out_stb_o | output | 1 | Pulse marking new output samples |
| muted_o | output | 1 | Gain is zero |

## Verification
Every result of this block is due one clock after the edge that captures a strobe. That edge loads the new gain, the scaled samples, the muted flag and the output strobe together. The bench raises a strobe at a falling edge and checks all four results at the next falling edge. It then lets at least one idle cycle pass and checks that the output strobe has dropped and that the samples hold. Validity is toggled between strobes and then proven harmless through the next strobe's output.

// File: rtl/smr_pkg.sv
package smr_pkg;
  localparam int DEF_DATA_W   = 24;
  localparam int DEF_GAIN_W   = 16;
  localparam int DEF_UP_STEPS = 960;
  localparam int DEF_DN_STEPS = 64;
  localparam int CH_COUNT     = 2;
  typedef enum logic {CH_LEFT = 1'b0, CH_RIGHT = 1'b1} chan_e;
endpackage

// File: rtl/smr_gain_ramp.sv
module smr_gain_ramp #(
  parameter int GAIN_W   = smr_pkg::DEF_GAIN_W,
  parameter int UP_STEPS = smr_pkg::DEF_UP_STEPS,
  parameter int DN_STEPS = smr_pkg::DEF_DN_STEPS
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              stb_i,
  input  logic              ok_i,
  output logic [GAIN_W-1:0] gain_nxt_o
);
  localparam int UNITY  = 1 << (GAIN_W - 1);
  localparam int UP_INC = (UNITY / UP_STEPS > 0) ? UNITY / UP_STEPS : 1;
  localparam int DN_INC = (UNITY + DN_STEPS - 1) / DN_STEPS;
  localparam logic [GAIN_W:0] UNITY_X = (GAIN_W + 1)'(UNITY);
  localparam logic [GAIN_W:0] UP_X    = (GAIN_W + 1)'(UP_INC);
  localparam logic [GAIN_W:0] DN_X    = (GAIN_W + 1)'(DN_INC);

  logic [GAIN_W-1:0] gain_q;
  logic [GAIN_W-1:0] step_val;
  logic [GAIN_W:0]   up_sum;

  // one step per strobe, direction picked by the validity flag
  always_comb begin
    up_sum = {1'b0, gain_q} + UP_X;
    if (ok_i) begin
      step_val = (up_sum >= UNITY_X) ? UNITY_X[GAIN_W-1:0] : up_sum[GAIN_W-1:0];
    end else begin
      step_val = ({1'b0, gain_q} <= DN_X) ? '0 : gain_q - DN_X[GAIN_W-1:0];
    end
  end

  assign gain_nxt_o = stb_i ? step_val : gain_q;

  always_ff @(posedge clk) begin
    if (rst) gain_q <= '0;
    else     gain_q <= gain_nxt_o;
  end

  // R4: gain never passes unity
  assert_gain_bound_R4: assert property (@(posedge clk) disable iff (rst)
    int'(gain_q) <= UNITY);
  // R8: no strobe, no movement
  assert_hold_no_stb_R8: assert property (@(posedge clk) disable iff (rst)
    !stb_i |=> $stable(gain_q));
  // R5: invalid flag never raises the gain
  assert_fall_dir_R5: assert property (@(posedge clk) disable iff (rst)
    stb_i && !ok_i |=> int'(gain_q) <= int'($past(gain_q)));
  // R4: valid flag never lowers the gain
  assert_rise_dir_R4: assert property (@(posedge clk) disable iff (rst)
    stb_i && ok_i |=> int'(gain_q) >= int'($past(gain_q)));
  // R6: bounded step, no jump on reversal
  assert_no_jump_R6: assert property (@(posedge clk) disable iff (rst)
    stb_i |=> ((int'(gain_q) - int'($past(gain_q))) <= UP_INC) &&
              ((int'($past(gain_q)) - int'(gain_q)) <= DN_INC));
  // R9: zero stays zero while invalid
  assert_stay_mute_R9: assert property (@(posedge clk) disable iff (rst)
    stb_i && !ok_i && (gain_q == '0) |=> gain_q == '0);
endmodule

// File: rtl/smr_scaler.sv
module smr_scaler #(
  parameter int DATA_W = smr_pkg::DEF_DATA_W,
  parameter int GAIN_W = smr_pkg::DEF_GAIN_W
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     stb_i,
  input  logic signed [DATA_W-1:0] x_i,
  input  logic        [GAIN_W-1:0] gain_i,
  output logic signed [DATA_W-1:0] y_o
);
  localparam int PW = DATA_W + GAIN_W + 2;
  localparam logic signed [PW-1:0] HALF = PW'(1) << (GAIN_W - 2);
  localparam logic signed [PW-1:0] MAXV = (PW'(1) << (DATA_W - 1)) - PW'(1);
  localparam logic signed [PW-1:0] MINV = ~MAXV;

  logic signed [PW-1:0]     prod_s;
  logic signed [PW-1:0]     rnd_s;
  logic signed [DATA_W-1:0] y_d;

  always_comb begin
    prod_s = PW'(x_i) * PW'(signed'({1'b0, gain_i}));
    rnd_s  = (prod_s + HALF) >>> (GAIN_W - 1);
    if (rnd_s > MAXV)      y_d = MAXV[DATA_W-1:0];
    else if (rnd_s < MINV) y_d = MINV[DATA_W-1:0];
    else                   y_d = rnd_s[DATA_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst)        y_o <= '0;
    else if (stb_i) y_o <= y_d;
  end

  // R7: a zero gain yields the zero code
  assert_zero_gain_R7: assert property (@(posedge clk) disable iff (rst)
    stb_i && (gain_i == '0) |=> y_o == '0);
  // R2: output holds between strobes
  assert_out_hold_R2: assert property (@(posedge clk) disable iff (rst)
    !stb_i |=> $stable(y_o));
endmodule

// File: rtl/soft_mute_ramp.sv
module soft_mute_ramp #(
  parameter int DATA_W   = smr_pkg::DEF_DATA_W,
  parameter int GAIN_W   = smr_pkg::DEF_GAIN_W,
  parameter int UP_STEPS = smr_pkg::DEF_UP_STEPS,
  parameter int DN_STEPS = smr_pkg::DEF_DN_STEPS
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     smp_stb_i,
  input  logic                     clk_ok_i,
  input  logic signed [DATA_W-1:0] left_i,
  input  logic signed [DATA_W-1:0] right_i,
  output logic signed [DATA_W-1:0] left_o,
  output logic signed [DATA_W-1:0] right_o,
  output logic                     out_stb_o,
  output logic                     muted_o
);
  import smr_pkg::*;

  logic [GAIN_W-1:0]        gain_nxt;
  logic signed [DATA_W-1:0] x_arr [CH_COUNT];
  logic signed [DATA_W-1:0] y_arr [CH_COUNT];

  smr_gain_ramp #(
    .GAIN_W  (GAIN_W),
    .UP_STEPS(UP_STEPS),
    .DN_STEPS(DN_STEPS)
  ) u_ramp (
    .clk       (clk),
    .rst       (rst),
    .stb_i     (smp_stb_i),
    .ok_i      (clk_ok_i),
    .gain_nxt_o(gain_nxt)
  );

  assign x_arr[CH_LEFT]  = left_i;
  assign x_arr[CH_RIGHT] = right_i;

  for (genvar ch = 0; ch < CH_COUNT; ch++) begin : g_chan
    smr_scaler #(
      .DATA_W(DATA_W),
      .GAIN_W(GAIN_W)
    ) u_scale (
      .clk   (clk),
      .rst   (rst),
      .stb_i (smp_stb_i),
      .x_i   (x_arr[ch]),
      .gain_i(gain_nxt),
      .y_o   (y_arr[ch])
    );
  end

  assign left_o  = y_arr[CH_LEFT];
  assign right_o = y_arr[CH_RIGHT];

  always_ff @(posedge clk) begin
    if (rst) begin
      out_stb_o <= 1'b0;
      muted_o   <= 1'b1;
    end else begin
      out_stb_o <= smp_stb_i;
      if (smp_stb_i) muted_o <= (gain_nxt == '0);
    end
  end

  // R7: muted means both channels at the zero code
  assert_muted_quiet_R7: assert property (@(posedge clk) disable iff (rst)
    muted_o |-> (left_o == '0) && (right_o == '0));
  // R2: output strobe follows the input strobe by one clock
  assert_stb_follow_R2: assert property (@(posedge clk) disable iff (rst)
    smp_stb_i |=> out_stb_o);
  assert_stb_quiet_R2: assert property (@(posedge clk) disable iff (rst)
    !smp_stb_i |=> !out_stb_o);
  // R8: muted flag moves only on a strobe
  assert_muted_hold_R8: assert property (@(posedge clk) disable iff (rst)
    !smp_stb_i |=> $stable(muted_o));
endmodule

// File: tb/tb_soft_mute_ramp.sv
`timescale 1ns/1ps
module tb_soft_mute_ramp;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic stb = 1'b0;
  logic ok  = 1'b0;
  logic signed [23:0] l_in = '0;
  logic signed [23:0] r_in = '0;
  logic signed [23:0] left_o, right_o;
  logic out_stb, muted;

  int n_cmp = 0;
  int n_bad = 0;
  int g_model = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  soft_mute_ramp dut (
    .clk(clk), .rst(rst), .smp_stb_i(stb), .clk_ok_i(ok),
    .left_i(l_in), .right_i(r_in), .left_o(left_o), .right_o(right_o),
    .out_stb_o(out_stb), .muted_o(muted)
  );

  function automatic int exp_scale(int x, int g);
    longint p;
    p = longint'(x) * longint'(g) + 64'sd16384;
    p = p >>> 15;
    if (p > 64'sd8388607) return 8388607;
    if (p < -64'sd8388608) return -8388608;
    return int'(p);
  endfunction

  function automatic int next_gain(int g, bit v);
    if (v) return (g + 34 > 32768) ? 32768 : g + 34;
    return (g <= 512) ? 0 : g - 512;
  endfunction

  function automatic int rnd_sample();
    int k;
    k = int'($urandom % 16);
    if (k == 0) return 8388607;
    if (k == 1) return -8388608;
    return $signed($urandom) >>> 8;
  endfunction

  task automatic chk(bit good, string tag, longint act, longint expv);
    n_cmp++;
    if (!good) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
    end
  endtask

  // strobe at a falling edge, results due at the next falling edge
  task automatic strobe(int lv, int rv, bit v, string tag);
    int el, er;
    logic signed [23:0] hl, hr;
    @(negedge clk);
    l_in = lv[23:0]; r_in = rv[23:0]; ok = v; stb = 1'b1;
    g_model = next_gain(g_model, v);
    el = exp_scale(lv, g_model);
    er = exp_scale(rv, g_model);
    @(negedge clk);
    stb = 1'b0;
    chk(out_stb == 1'b1, {tag, " R2 out_stb"}, out_stb, 1);
    chk(int'(left_o) == el, {tag, " R3 left"}, left_o, el);
    chk(int'(right_o) == er, {tag, " R3 right"}, right_o, er);
    chk(muted == (g_model == 0), {tag, " R7 muted"}, muted, g_model == 0);
    hl = left_o; hr = right_o;
    repeat (1 + ($urandom % 3)) @(negedge clk);
    chk(out_stb == 1'b0, {tag, " R2 out_stb low"}, out_stb, 0);
    chk(left_o == hl && right_o == hr, {tag, " R2 hold"}, left_o, hl);
  endtask

  initial begin
    void'($urandom(32'd4711));
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk(muted == 1'b1, "R1 muted", muted, 1);
    chk(left_o == 0 && right_o == 0, "R1 outputs", left_o, 0);
    chk(out_stb == 1'b0, "R1 out_stb", out_stb, 0);

    // R9: invalid strobes while muted keep silence
    for (int i = 0; i < 5; i++) strobe(rnd_sample(), rnd_sample(), 1'b0, "R9");

    // R8: flag toggles with no strobe
    ok = 1'b1;
    repeat (10) @(negedge clk);
    ok = 1'b0;
    @(negedge clk);
    chk(muted == 1'b1 && left_o == 0, "R8 no strobe", muted, 1);
    strobe(8388607, -8388608, 1'b0, "R8 after toggle");
    chk(g_model == 0, "R8 model gain", g_model, 0);

    // R4: full soft start; muted drops on first, unity on 964th
    for (int i = 1; i <= 970; i++) begin
      strobe(rnd_sample(), rnd_sample(), 1'b1, "R4 rise");
      if (i == 963) chk(g_model != 32768, "R4 not yet unity", g_model, 32742);
    end
    strobe(8388607, -8388608, 1'b1, "R4 unity");
    chk(int'(left_o) == 8388607 && int'(right_o) == -8388608,
        "R4 passthrough", left_o, 8388607);

    // R5: fall from unity, silent exactly at 64th strobe
    for (int i = 1; i <= 64; i++) begin
      strobe(8388607, rnd_sample(), 1'b0, "R5 fall");
      chk(muted == (i == 64), "R5 mute timing", muted, i == 64);
    end

    // R6: reversals mid-ramp
    for (int i = 0; i < 100; i++) strobe(rnd_sample(), rnd_sample(), 1'b1, "R6 up");
    for (int i = 0; i < 3; i++)   strobe(8388607, -8388608, 1'b0, "R6 down");
    for (int i = 0; i < 5; i++)   strobe(8388607, -8388608, 1'b1, "R6 up again");
    while (g_model != 0) strobe(rnd_sample(), rnd_sample(), 1'b0, "R6 down to zero");

    // mixed random validity, R3 arithmetic throughout
    for (int i = 0; i < 1500; i++)
      strobe(rnd_sample(), rnd_sample(), ($urandom % 8) != 0, "R3 random");

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog R2 actual=timeout expected=completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule